// File: doc/BRIEF.md
# Prescaled Periodic Tick Timer Bank

This block is a small bank of identical down-counting timers meant to produce the regular system tick of a processor. Each timer sits in its own 256-byte slot of one register window and is driven over a plain register bus: an address, a write strobe, write data and a combinational read-data return. A timer holds a 16-bit live count, a 16-bit reload value and a control byte. The control byte carries the enable, the reload (periodic) mode and a two-bit clock prescaler. Each timer has its own level interrupt line.

Software stops a timer, writes the reload value and a separate starting count, then enables it. The first period can therefore differ from the later ones. In periodic mode the count runs down and reloads on expiry. In free-running mode it wraps through zero to the all-ones value. Either kind of expiry latches the timer's interrupt, and the interrupt stays set until software writes anything to that timer's clear register.

Top module: `tick_timer_bank`

## Requirements
- R1: After reset, every timer's reload, count and control registers read as zero, and all interrupt lines are low.
- R2: Timer n occupies byte addresses n*0x100 upward, for n = 0, 1, 2. Within a slot, word offset 0x0 holds the reload value, 0x4 the live count, 0x8 the control byte and 0xC the interrupt clear. An access is ignored if its address has bits 1:0 nonzero, bits 7:4 nonzero, or a slot number above 2. Such a read returns 0 and such a write changes nothing.
- R3: The control register keeps only bit 7 (enable), bit 6 (periodic mode) and bits 3:2 (prescale code), and reads back with every other bit zero. Reload and count read back in bits 15:0 with bits 31:16 zero. The clear register always reads zero.
- R4: An enabled timer with prescale code 00 decrements its count by one on every clock edge, starting with the first edge after the edge that wrote the control register.
- R5: In periodic mode, a counting step taken while the count is 1 (or 0) loads the reload value instead of decrementing, and sets the interrupt. A reload value of N gives an interrupt every N steps.
- R6: With periodic mode off, the count steps from 0 to 0xFFFF and carries on downward. The step out of 0 sets the interrupt.
- R7: Prescale code 01 gives one counting step per 16 clocks, code 10 one per 256 clocks, and codes 00 and 11 one per clock. The first step comes that many clocks after the control write.
- R8: Every write to the control register restarts the prescaler, so the next step comes a full prescale period after that write. The writing cycle itself takes no step.
- R9: The interrupt is a sticky level that stays high until a write of any data to the timer's clear register. An expiry in the same cycle as a clear leaves it set.
- R10: Writing the control register with bit 7 clear stops the count. The count then holds its value, and the interrupt keeps its value.
- R11: A write to the count register loads that value at the write edge and overrides any counting step in the same cycle. It does not change the reload register, and later reloads still use the reload value.
- R12: Timers are independent. Programming, running or clearing one timer leaves the count and interrupt of the others unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 12 | Byte address within the timer window |
| bus_we | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| irq | output | 3 | Per-timer sticky interrupt level |

## Verification
A register write takes effect on the clock edge that samples it, so read-back and interrupt-clear results are due immediately after that edge. Counting results are due on the k-th edge after the control write, where k is the number of steps times the prescale divisor. The bench drives every access just after a falling edge. It waits a known number of falling edges and reads the count and interrupt before the next rising edge, so every expected value is tied to a counted number of edges. Randomised runs compute the expected count and interrupt from a step-by-step model of the counting rule, applied to the number of whole prescale periods elapsed.

// File: rtl/ptimer_pkg.sv
`timescale 1ns/1ps
package ptimer_pkg;

    // Word select inside a timer slot (address bits 3:2)
    typedef enum logic [1:0] {
        REG_RELOAD = 2'd0,
        REG_COUNT  = 2'd1,
        REG_CTRL   = 2'd2,
        REG_CLEAR  = 2'd3
    } reg_sel_e;

    // Control byte bit positions
    localparam int CTRL_RUN_BIT = 7;
    localparam int CTRL_PER_BIT = 6;
    localparam int CTRL_PSC_LSB = 2;

    // Prescale codes
    typedef enum logic [1:0] {
        PSC_DIV1   = 2'd0,
        PSC_DIV16  = 2'd1,
        PSC_DIV256 = 2'd2,
        PSC_SPARE  = 2'd3
    } psc_e;

    typedef struct packed {
        logic run;
        logic reload_mode;
        psc_e psc;
    } tmr_ctrl_t;

    localparam int PRE_W = 8;

    // Last prescaler value before a counting step is issued
    function automatic logic [PRE_W-1:0] psc_terminal(input psc_e p);
        case (p)
            PSC_DIV16:  return PRE_W'(15);
            PSC_DIV256: return PRE_W'(255);
            default:    return '0;
        endcase
    endfunction

    function automatic tmr_ctrl_t ctrl_from_byte(input logic [7:0] b);
        tmr_ctrl_t c;
        c.run         = b[CTRL_RUN_BIT];
        c.reload_mode = b[CTRL_PER_BIT];
        c.psc         = psc_e'(b[CTRL_PSC_LSB +: 2]);
        return c;
    endfunction

    function automatic logic [7:0] ctrl_to_byte(input tmr_ctrl_t c);
        logic [7:0] b;
        b = '0;
        b[CTRL_RUN_BIT]      = c.run;
        b[CTRL_PER_BIT]      = c.reload_mode;
        b[CTRL_PSC_LSB +: 2] = c.psc;
        return b;
    endfunction

endpackage

// File: rtl/ptimer_prescaler.sv
`timescale 1ns/1ps
module ptimer_prescaler
    import ptimer_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic run,
    input  logic restart,
    input  psc_e psc,
    output logic tick
);

    logic [PRE_W-1:0] pre_q;
    logic [PRE_W-1:0] pre_end;

    assign pre_end = psc_terminal(psc);
    // The control write cycle never issues a step
    assign tick    = run && !restart && (pre_q == pre_end);

    always_ff @(posedge clk) begin
        if (rst || restart || !run) begin
            pre_q <= '0;
        end else if (pre_q == pre_end) begin
            pre_q <= '0;
        end else begin
            pre_q <= pre_q + PRE_W'(1);
        end
    end

endmodule

// File: rtl/ptimer_channel.sv
`timescale 1ns/1ps
module ptimer_channel
    import ptimer_pkg::*;
#(
    parameter int CNT_W  = 16,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  reg_sel_e          reg_sel,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    output logic              irq,
    output logic              tick_o,
    output logic              expire_o,
    output logic [CNT_W-1:0]  count_o
);

    logic [CNT_W-1:0] reload_q;
    logic [CNT_W-1:0] count_q;
    tmr_ctrl_t        ctrl_q;
    logic             irq_q;

    logic wr_reload, wr_count, wr_ctrl, wr_clear;
    logic tick, at_end, expire;
    logic unused_wdata_hi;

    assign wr_reload = wr_en && (reg_sel == REG_RELOAD);
    assign wr_count  = wr_en && (reg_sel == REG_COUNT);
    assign wr_ctrl   = wr_en && (reg_sel == REG_CTRL);
    assign wr_clear  = wr_en && (reg_sel == REG_CLEAR);

    assign unused_wdata_hi = ^wdata[DATA_W-1:CNT_W];

    ptimer_prescaler u_pre (
        .clk     (clk),
        .rst     (rst),
        .run     (ctrl_q.run),
        .restart (wr_ctrl),
        .psc     (ctrl_q.psc),
        .tick    (tick)
    );

    // Expiry: periodic mode at 1 (or 0) reloads, free mode wraps out of 0
    assign at_end = ctrl_q.reload_mode ? (count_q <= CNT_W'(1))
                                       : (count_q == '0);
    assign expire = tick && !wr_count && at_end;

    always_ff @(posedge clk) begin
        if (rst) begin
            reload_q <= '0;
            ctrl_q   <= '0;
        end else begin
            if (wr_reload) reload_q <= wdata[CNT_W-1:0];
            if (wr_ctrl)   ctrl_q   <= ctrl_from_byte(wdata[7:0]);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            count_q <= '0;
        end else if (wr_count) begin
            count_q <= wdata[CNT_W-1:0];
        end else if (tick) begin
            if (ctrl_q.reload_mode && (count_q <= CNT_W'(1))) begin
                count_q <= reload_q;
            end else begin
                count_q <= count_q - CNT_W'(1);
            end
        end
    end

    // Sticky interrupt: a fresh expiry beats a simultaneous clear
    always_ff @(posedge clk) begin
        if (rst) begin
            irq_q <= 1'b0;
        end else if (expire) begin
            irq_q <= 1'b1;
        end else if (wr_clear) begin
            irq_q <= 1'b0;
        end
    end

    always_comb begin
        case (reg_sel)
            REG_RELOAD: rdata = DATA_W'(reload_q);
            REG_COUNT:  rdata = DATA_W'(count_q);
            REG_CTRL:   rdata = DATA_W'(ctrl_to_byte(ctrl_q));
            default:    rdata = '0;
        endcase
    end

    assign irq      = irq_q;
    assign tick_o   = tick;
    assign expire_o = expire;
    assign count_o  = count_q;

endmodule

// File: rtl/ptimer_decode.sv
`timescale 1ns/1ps
module ptimer_decode
    import ptimer_pkg::*;
#(
    parameter int NUM_TIMERS = 3,
    parameter int ADDR_W     = 12,
    parameter int STRIDE_LSB = 8
) (
    input  logic [ADDR_W-1:0]     addr,
    input  logic                  we,
    output logic [NUM_TIMERS-1:0] slot_hit,
    output logic [NUM_TIMERS-1:0] wr_strobe,
    output reg_sel_e              reg_sel
);

    localparam int SLOT_W = ADDR_W - STRIDE_LSB;

    logic [SLOT_W-1:0] slot;
    logic              inner_ok;

    assign slot     = addr[ADDR_W-1:STRIDE_LSB];
    assign inner_ok = (addr[STRIDE_LSB-1:4] == '0) && (addr[1:0] == 2'b00);
    assign reg_sel  = reg_sel_e'(addr[3:2]);

    for (genvar i = 0; i < NUM_TIMERS; i++) begin : g_slot
        assign slot_hit[i]  = inner_ok && (slot == SLOT_W'(i));
        assign wr_strobe[i] = we && slot_hit[i];
    end

endmodule

// File: rtl/tick_timer_bank.sv
`timescale 1ns/1ps
module tick_timer_bank
    import ptimer_pkg::*;
#(
    parameter int NUM_TIMERS = 3,
    parameter int CNT_W      = 16,
    parameter int ADDR_W     = 12,
    parameter int DATA_W     = 32,
    parameter int STRIDE_LSB = 8
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic [ADDR_W-1:0]     bus_addr,
    input  logic                  bus_we,
    input  logic [DATA_W-1:0]     bus_wdata,
    output logic [DATA_W-1:0]     bus_rdata,
    output logic [NUM_TIMERS-1:0] irq
);

    logic [NUM_TIMERS-1:0]             slot_hit;
    logic [NUM_TIMERS-1:0]             wr_strobe;
    reg_sel_e                          reg_sel;
    logic [NUM_TIMERS-1:0][DATA_W-1:0] ch_rdata;
    logic [NUM_TIMERS-1:0]             ch_tick;
    logic [NUM_TIMERS-1:0]             ch_expire;
    logic [NUM_TIMERS-1:0][CNT_W-1:0]  ch_count;

    ptimer_decode #(
        .NUM_TIMERS (NUM_TIMERS),
        .ADDR_W     (ADDR_W),
        .STRIDE_LSB (STRIDE_LSB)
    ) u_dec (
        .addr      (bus_addr),
        .we        (bus_we),
        .slot_hit  (slot_hit),
        .wr_strobe (wr_strobe),
        .reg_sel   (reg_sel)
    );

    for (genvar i = 0; i < NUM_TIMERS; i++) begin : g_tmr
        ptimer_channel #(
            .CNT_W  (CNT_W),
            .DATA_W (DATA_W)
        ) u_ch (
            .clk      (clk),
            .rst      (rst),
            .wr_en    (wr_strobe[i]),
            .reg_sel  (reg_sel),
            .wdata    (bus_wdata),
            .rdata    (ch_rdata[i]),
            .irq      (irq[i]),
            .tick_o   (ch_tick[i]),
            .expire_o (ch_expire[i]),
            .count_o  (ch_count[i])
        );
    end

    always_comb begin
        bus_rdata = '0;
        for (int i = 0; i < NUM_TIMERS; i++) begin
            if (slot_hit[i]) bus_rdata = bus_rdata | ch_rdata[i];
        end
    end

endmodule

// File: rtl/tick_timer_bank_chk.sv
`timescale 1ns/1ps
module tick_timer_bank_chk
    import ptimer_pkg::*;
#(
    parameter int NUM    = 3,
    parameter int CNT_W  = 16,
    parameter int DATA_W = 32
) (
    input logic                       clk,
    input logic                       rst,
    input logic [NUM-1:0]             slot_hit,
    input logic [NUM-1:0]             wr_strobe,
    input reg_sel_e                   reg_sel,
    input logic [DATA_W-1:0]          bus_rdata,
    input logic [NUM-1:0]             irq,
    input logic [NUM-1:0]             tick,
    input logic [NUM-1:0]             expire,
    input logic [NUM-1:0][CNT_W-1:0]  count
);

    // R2
    wr_onehot_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0(wr_strobe));

    // R3
    clear_reads_zero_chk: assert property (@(posedge clk) disable iff (rst)
        ((|slot_hit) && (reg_sel == REG_CLEAR)) |-> (bus_rdata == '0));

    for (genvar i = 0; i < NUM; i++) begin : g_chk
        logic clr_w, cnt_w;
        assign clr_w = wr_strobe[i] && (reg_sel == REG_CLEAR);
        assign cnt_w = wr_strobe[i] && (reg_sel == REG_COUNT);

        // R9
        irq_needs_expiry_chk: assert property (@(posedge clk) disable iff (rst)
            $rose(irq[i]) |-> $past(expire[i]));

        // R9
        irq_sticky_chk: assert property (@(posedge clk) disable iff (rst)
            (irq[i] && !clr_w) |=> irq[i]);

        // R9
        irq_clear_chk: assert property (@(posedge clk) disable iff (rst)
            (clr_w && !expire[i]) |=> !irq[i]);

        // R10
        count_hold_chk: assert property (@(posedge clk) disable iff (rst)
            (!tick[i] && !cnt_w) |=> $stable(count[i]));
    end

endmodule

bind tick_timer_bank tick_timer_bank_chk #(
    .NUM    (NUM_TIMERS),
    .CNT_W  (CNT_W),
    .DATA_W (DATA_W)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .slot_hit  (slot_hit),
    .wr_strobe (wr_strobe),
    .reg_sel   (reg_sel),
    .bus_rdata (bus_rdata),
    .irq       (irq),
    .tick      (ch_tick),
    .expire    (ch_expire),
    .count     (ch_count)
);

// File: tb/tick_timer_bank_bench.sv
`timescale 1ns/1ps
module tick_timer_bank_bench;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [11:0] bus_addr = '0;
    logic        bus_we = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [2:0]  irq;

    int  checks = 0;
    int  errors = 0;
    bit  done   = 1'b0;

    always #2 clk = ~clk;

    tick_timer_bank u_tick_timer_bank (
        .clk       (clk),
        .rst       (rst),
        .bus_addr  (bus_addr),
        .bus_we    (bus_we),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .irq       (irq)
    );

    localparam int O_RLD = 0, O_CNT = 4, O_CTL = 8, O_CLR = 12;

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // Called just after a falling edge; returns at the next falling edge
    task automatic wr(input int slot, input int off, input logic [31:0] d);
        bus_addr  = 12'(slot * 256 + off);
        bus_wdata = d;
        bus_we    = 1'b1;
        @(negedge clk);
        bus_we    = 1'b0;
    endtask

    task automatic rd_chk(input int slot, input int off, input logic [31:0] exp,
                          input string req, input string what);
        bus_addr = 12'(slot * 256 + off);
        bus_we   = 1'b0;
        #0.1;
        check(req, what, bus_rdata, exp);
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic setup(input int slot, input logic [15:0] rl,
                         input logic [15:0] st, input logic [7:0] ctl);
        wr(slot, O_CTL, 32'h0);
        wr(slot, O_CLR, $urandom);
        wr(slot, O_RLD, {16'h0, rl});
        wr(slot, O_CNT, {16'h0, st});
        wr(slot, O_CTL, {24'h0, ctl});
    endtask

    // Expected {irq_fired, count} after n counting steps
    function automatic logic [16:0] model(input logic [15:0] st, input logic [15:0] rl,
                                          input bit per, input int n);
        logic [15:0] c;
        logic        f;
        c = st;
        f = 1'b0;
        for (int s = 0; s < n; s++) begin
            if (per) begin
                if (c <= 16'd1) begin c = rl; f = 1'b1; end
                else c = c - 16'd1;
            end else begin
                if (c == 16'd0) f = 1'b1;
                c = c - 16'd1;
            end
        end
        return {f, c};
    endfunction

    function automatic int divisor(input int code);
        return (code == 1) ? 16 : (code == 2) ? 256 : 1;
    endfunction

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd7731));
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1 reset state
        for (int s = 0; s < 3; s++) begin
            rd_chk(s, O_RLD, 32'h0, "R1", "reload after reset");
            rd_chk(s, O_CNT, 32'h0, "R1", "count after reset");
            rd_chk(s, O_CTL, 32'h0, "R1", "control after reset");
        end
        check("R1", "irq after reset", {29'h0, irq}, 32'h0);

        // R3 read-back masking
        wr(0, O_CTL, 32'hFFFF_FFFF);
        rd_chk(0, O_CTL, 32'h0000_00CC, "R3", "control read-back mask");
        wr(0, O_RLD, 32'hABCD_1234);
        rd_chk(0, O_RLD, 32'h0000_1234, "R3", "reload upper bits zero");
        rd_chk(0, O_CLR, 32'h0, "R3", "clear register reads zero");
        wr(0, O_CTL, 32'h0);

        // R4 / R5 periodic at /1
        setup(0, 16'd5, 16'd3, 8'hC0);
        cyc(2);
        rd_chk(0, O_CNT, 32'd1, "R4", "count after two steps");
        check("R5", "irq before expiry", {31'h0, irq[0]}, 32'd0);
        cyc(1);
        rd_chk(0, O_CNT, 32'd5, "R5", "reload on expiry");
        check("R5", "irq on expiry", {31'h0, irq[0]}, 32'd1);
        cyc(5);
        rd_chk(0, O_CNT, 32'd5, "R5", "full period later");
        check("R9", "irq stays set", {31'h0, irq[0]}, 32'd1);
        wr(0, O_CLR, 32'h1234_5678);
        check("R9", "irq cleared", {31'h0, irq[0]}, 32'd0);
        rd_chk(0, O_CNT, 32'd4, "R4", "count stepped during clear");
        cyc(4);
        check("R5", "second period irq", {31'h0, irq[0]}, 32'd1);

        // R10 stop
        wr(0, O_CTL, 32'h0);
        cyc(50);
        rd_chk(0, O_CNT, 32'd5, "R10", "count frozen when stopped");
        check("R10", "irq kept when stopped", {31'h0, irq[0]}, 32'd1);

        // R6 free-running wrap
        setup(1, 16'd100, 16'd2, 8'h80);
        cyc(2);
        rd_chk(1, O_CNT, 32'd0, "R6", "count reaches zero");
        check("R6", "no irq at zero", {31'h0, irq[1]}, 32'd0);
        cyc(1);
        rd_chk(1, O_CNT, 32'h0000_FFFF, "R6", "wrap to all ones");
        check("R6", "irq on wrap", {31'h0, irq[1]}, 32'd1);
        rd_chk(0, O_CNT, 32'd5, "R12", "timer 0 untouched");
        check("R12", "timer 0 irq untouched", {31'h0, irq[0]}, 32'd1);

        // R11 count write independent of reload
        setup(2, 16'd7, 16'd20, 8'hC0);
        cyc(3);
        rd_chk(2, O_CNT, 32'd17, "R11", "first period from count");
        rd_chk(2, O_RLD, 32'd7, "R11", "reload unchanged");
        wr(2, O_CNT, 32'd2);
        rd_chk(2, O_CNT, 32'd2, "R11", "write beats step");
        cyc(1);
        rd_chk(2, O_CNT, 32'd1, "R11", "counts from written value");
        check("R11", "no irq yet", {31'h0, irq[2]}, 32'd0);
        cyc(1);
        rd_chk(2, O_CNT, 32'd7, "R11", "reload value used");
        check("R11", "irq after rewrite", {31'h0, irq[2]}, 32'd1);

        // R7 divide by 16
        setup(0, 16'd9, 16'd4, 8'hC4);
        cyc(15);
        rd_chk(0, O_CNT, 32'd4, "R7", "no step before 16 clocks");
        cyc(1);
        rd_chk(0, O_CNT, 32'd3, "R7", "step at 16 clocks");

        // R8 prescaler restart
        setup(0, 16'd9, 16'd10, 8'hC4);
        cyc(10);
        wr(0, O_CTL, 32'hC4);
        cyc(10);
        rd_chk(0, O_CNT, 32'd10, "R8", "restart delays step");
        cyc(6);
        rd_chk(0, O_CNT, 32'd9, "R8", "step a full period after rewrite");

        // R7 divide by 256
        setup(1, 16'd3, 16'd3, 8'hC8);
        cyc(255);
        rd_chk(1, O_CNT, 32'd3, "R7", "no step before 256 clocks");
        cyc(1);
        rd_chk(1, O_CNT, 32'd2, "R7", "step at 256 clocks");

        // R7 spare code acts as /1
        setup(2, 16'd9, 16'd5, 8'hCC);
        cyc(1);
        rd_chk(2, O_CNT, 32'd4, "R7", "code 11 steps every clock");

        // R2 ignored accesses
        wr(0, O_CTL, 32'h0);
        wr(1, O_CTL, 32'h0);
        wr(2, O_CTL, 32'h0);
        wr(3, O_RLD, 32'h55);
        wr(0, 16, 32'h77);
        wr(0, 1, 32'h66);
        rd_chk(3, O_RLD, 32'h0, "R2", "slot 3 reads zero");
        rd_chk(0, 16, 32'h0, "R2", "inner offset reads zero");
        rd_chk(0, O_RLD, 32'd9, "R2", "reload kept after ignored writes");

        // Random runs, R5 R6 R7
        for (int k = 0; k < 6; k++) begin
            automatic int          slot = $urandom_range(0, 2);
            automatic int          code = $urandom_range(0, 3);
            automatic bit          per  = 1'($urandom_range(0, 1));
            automatic logic [15:0] rl   = 16'($urandom_range(1, 40));
            automatic logic [15:0] st   = 16'($urandom_range(1, 40));
            automatic int          nt   = $urandom_range(0, 40);
            automatic int          d    = divisor(code);
            automatic int          ex   = $urandom_range(0, d - 1);
            automatic logic [16:0] m;
            setup(slot, rl, st, 8'h80 | (8'(per) << 6) | (8'(code) << 2));
            cyc(nt * d + ex);
            m = model(st, rl, per, nt);
            rd_chk(slot, O_CNT, {16'h0, m[15:0]}, "R7", "random count");
            check(per ? "R5" : "R6", "random irq", {31'h0, irq[slot]}, {31'h0, m[16]});
            wr(slot, O_CTL, 32'h0);
        end

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule